// File: doc/BRIEF.md
# Stack frame sequencer

This block is the stack engine of an 8-bit processor with a 16-bit address space. It holds the stack pointer and moves bytes between the processor and a byte-wide memory port. The stack grows toward lower addresses, and the pointer always names the next free byte. Six commands are supported: load the pointer, push one byte, pull one byte, save a return address, recover a return address, and save or restore a full interrupt context.

Instruction decode, vector fetch and the register file stay outside the block. Register values arrive on context ports, and restored values leave on matching output ports. Only one memory access takes place per clock. Memory reads are combinational, so read data is taken in the same cycle the read strobe is high. Every command ends with a one-cycle done pulse. A command that arrives while the block is busy is dropped.

Top module: `stack_seq`

## Requirements
- R1: While reset is high, and after it is released, the pointer is 0x0000, busy and done are low, and neither memory strobe is active.
- R2: Opcode 0 (load) is accepted while idle and sets the pointer to cmd_data at that clock edge. Done pulses in the next cycle and no memory access is made.
- R3: Opcode 1 (push) makes one write of cmd_data[7:0] at the current pointer. The pointer then drops by one.
- R4: Opcode 2 (pull) makes one read at pointer+1. The pointer rises by one, and the byte read appears on pull_data once done is seen.
- R5: Opcode 3 (call save) writes the return address on cmd_data in two cycles: the low byte at the pointer, then the high byte one address below. The pointer ends 2 lower.
- R6: Opcode 4 (return) makes two reads at ascending addresses. The first byte becomes the high byte of out_pc and the second byte becomes the low byte. The pointer ends 2 higher.
- R7: Opcode 5 (interrupt save) writes nine bytes at descending addresses in this order: PC low, PC high, Y low, Y high, X low, X high, A, B, CCR. The pointer ends 9 lower.
- R8: Opcode 6 (interrupt restore) reads nine bytes at ascending addresses in the exact reverse of the save order. Afterwards out_pc, out_y, out_x, out_a, out_b and out_ccr hold the restored values.
- R9: Pointer arithmetic wraps modulo 2^16. A push at 0x0000 leaves the pointer at 0xFFFF, and a pull at 0xFFFF reads address 0x0000.
- R10: An accepted command of N accesses holds busy high for the N cycles that follow acceptance, with exactly one access per cycle. Done is high for one cycle right after the last access.
- R11: Any command presented while busy is high is ignored. Opcode 7 is ignored at all times: it makes no access, no done pulse and no pointer change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode (0..7) |
| cmd_data | input | 16 | Load value, push byte in [7:0], or return address |
| ctx_pc | input | 16 | Program counter to save on interrupt |
| ctx_y | input | 16 | Y index register to save |
| ctx_x | input | 16 | X index register to save |
| ctx_a | input | 8 | Accumulator A to save |
| ctx_b | input | 8 | Accumulator B to save |
| ctx_ccr | input | 8 | Condition code register to save |
| mem_rdata | input | 8 | Combinational read data from memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read strobe |
| busy | output | 1 | Multi-cycle command in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Current stack pointer |
| pull_data | output | 8 | Byte returned by the last pull |
| out_pc | output | 16 | Restored program counter or return address |
| out_y | output | 16 | Restored Y |
| out_x | output | 16 | Restored X |
| out_a | output | 8 | Restored A |
| out_b | output | 8 | Restored B |
| out_ccr | output | 8 | Restored condition code register |

## Verification
A pointer that is off by one or moves the wrong way shows up on the address bus at the very next access. The bench compares every strobe cycle with its queue of expected address, direction and data, so such a fault is reported in the cycle it happens. A byte-index fault in the frame sequence gives wrong write data during a save, or a swapped field on the restore outputs when done arrives. A fault in the step counter shows as busy held for the wrong number of cycles, a done pulse in the wrong cycle, or an access nobody expected.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int ADDR_W      = 16;
    localparam int FRAME_BYTES = 9;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_PULL  = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_ISAVE = 3'd5,
        OP_IREST = 3'd6,
        OP_NOP   = 3'd7
    } stk_op_e;

    // Byte slot k holds the k-th byte pushed in a frame save.
    typedef logic [FRAME_BYTES-1:0][7:0] frame_t;

    function automatic frame_t pack_frame(input logic [15:0] pc,
                                          input logic [15:0] y,
                                          input logic [15:0] x,
                                          input logic [7:0]  a,
                                          input logic [7:0]  b,
                                          input logic [7:0]  ccr);
        frame_t f;
        f[0] = pc[7:0];
        f[1] = pc[15:8];
        f[2] = y[7:0];
        f[3] = y[15:8];
        f[4] = x[7:0];
        f[5] = x[15:8];
        f[6] = a;
        f[7] = b;
        f[8] = ccr;
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] op_len(input stk_op_e op);
        case (op)
            OP_PUSH, OP_PULL:   return IDX_W'(1);
            OP_CALL, OP_RET:    return IDX_W'(2);
            OP_ISAVE, OP_IREST: return IDX_W'(FRAME_BYTES);
            default:            return '0;
        endcase
    endfunction

    function automatic logic op_writes(input stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_ISAVE);
    endfunction

    function automatic logic op_reads(input stk_op_e op);
        return (op == OP_PULL) || (op == OP_RET) || (op == OP_IREST);
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          dec,
    input  logic          inc,
    output logic [AW-1:0] sp
);
    always_ff @(posedge clk) begin
        if (rst)      sp <= '0;
        else if (ld)  sp <= ld_val;
        else if (dec) sp <= sp - AW'(1);
        else if (inc) sp <= sp + AW'(1);
    end
endmodule

// File: rtl/stk_ctl.sv
module stk_ctl
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  stk_op_e          cmd_op,
    output logic             busy,
    output logic             done,
    output logic             wr,
    output logic             rd,
    output logic [IDX_W-1:0] idx,
    output logic             ld_accept,
    output logic             cap_accept
);
    stk_op_e          op_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] len;
    logic             accept;

    assign accept     = cmd_valid && !busy && (cmd_op != OP_NOP);
    assign ld_accept  = accept && (cmd_op == OP_LOAD);
    assign cap_accept = accept && op_writes(cmd_op);
    assign len        = op_len(op_q);
    assign wr         = busy && op_writes(op_q);
    assign rd         = busy && op_reads(op_q);
    assign idx        = wr ? cnt_q : (len - IDX_W'(1) - cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
            op_q  <= OP_NOP;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (cmd_op == OP_LOAD) begin
                    done <= 1'b1;
                end else begin
                    busy  <= 1'b1;
                    op_q  <= cmd_op;
                    cnt_q <= '0;
                end
            end else if (busy) begin
                if (cnt_q == len - IDX_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + IDX_W'(1);
                end
            end
        end
    end

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < IDX_W'(FRAME_BYTES)));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/stk_frame.sv
module stk_frame
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  frame_t           cap_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    output frame_t           frame
);
    always_ff @(posedge clk) begin
        if (rst)        frame <= '0;
        else if (cap)   frame <= cap_val;
        else if (wr_en) frame[wr_idx] <= wr_byte;
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_data,
    input  logic [15:0]       ctx_pc,
    input  logic [15:0]       ctx_y,
    input  logic [15:0]       ctx_x,
    input  logic [7:0]        ctx_a,
    input  logic [7:0]        ctx_b,
    input  logic [7:0]        ctx_ccr,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] sp,
    output logic [7:0]        pull_data,
    output logic [15:0]       out_pc,
    output logic [15:0]       out_y,
    output logic [15:0]       out_x,
    output logic [7:0]        out_a,
    output logic [7:0]        out_b,
    output logic [7:0]        out_ccr
);
    stk_op_e          op;
    logic             wr, rd, ld_accept, cap_accept;
    logic [IDX_W-1:0] idx;
    frame_t           frm, cap_val;

    assign op = stk_op_e'(cmd_op);

    stk_ctl u_ctl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op),
        .busy(busy), .done(done), .wr(wr), .rd(rd), .idx(idx),
        .ld_accept(ld_accept), .cap_accept(cap_accept)
    );

    stk_ptr #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .ld(ld_accept), .ld_val(cmd_data),
        .dec(wr), .inc(rd), .sp(sp)
    );

    // Push and call carry their bytes on cmd_data; interrupt save uses the PC port.
    assign cap_val = pack_frame((op == OP_ISAVE) ? ctx_pc : cmd_data,
                                ctx_y, ctx_x, ctx_a, ctx_b, ctx_ccr);

    stk_frame u_frame (
        .clk(clk), .rst(rst), .cap(cap_accept), .cap_val(cap_val),
        .wr_en(rd), .wr_idx(idx), .wr_byte(mem_rdata), .frame(frm)
    );

    assign mem_we    = wr;
    assign mem_re    = rd;
    assign mem_addr  = wr ? sp : sp + ADDR_W'(1);
    assign mem_wdata = frm[idx];

    assign pull_data = frm[0];
    assign out_pc    = {frm[1], frm[0]};
    assign out_y     = {frm[3], frm[2]};
    assign out_x     = {frm[5], frm[4]};
    assign out_a     = frm[6];
    assign out_b     = frm[7];
    assign out_ccr   = frm[8];

    assert_push_step_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - ADDR_W'(1)));
    assert_pull_step_R4: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (sp == $past(sp) + ADDR_W'(1)));
    assert_one_access_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    assert_access_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd0) |=> (sp == $past(cmd_data)));
    assert_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd7 && !busy) |=> ($stable(sp) && !done));
endmodule

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_data, ctx_pc, ctx_y, ctx_x;
    logic [7:0]  ctx_a, ctx_b, ctx_ccr, mem_rdata;
    logic [15:0] mem_addr, sp, out_pc, out_y, out_x;
    logic [7:0]  mem_wdata, pull_data, out_a, out_b, out_ccr;
    logic        mem_we, mem_re, busy, done;

    always #4 clk = ~clk;

    stack_seq u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .ctx_pc(ctx_pc), .ctx_y(ctx_y), .ctx_x(ctx_x),
        .ctx_a(ctx_a), .ctx_b(ctx_b), .ctx_ccr(ctx_ccr), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .busy(busy), .done(done), .sp(sp),
        .pull_data(pull_data), .out_pc(out_pc), .out_y(out_y), .out_x(out_x),
        .out_a(out_a), .out_b(out_b), .out_ccr(out_ccr)
    );

    logic [7:0] mem [256];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } acc_t;
    acc_t exp_q[$];

    int total = 0;
    int bad = 0;
    logic [15:0] sp_m;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic exp_wr(logic [15:0] a, logic [7:0] d, string req);
        acc_t e;
        e.we = 1'b1; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic exp_rd(logic [15:0] a, string req);
        acc_t e;
        e.we = 1'b0; e.addr = a; e.data = 8'h00; e.req = req;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor: every strobe cycle must match the next expected access.
    always @(negedge clk) begin
        acc_t e;
        if (!rst && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                chk("R10", "unexpected access", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                chk(e.req, "access kind", {31'd0, mem_we}, {31'd0, e.we});
                chk(e.req, "address", {16'd0, mem_addr}, {16'd0, e.addr});
                if (e.we) chk(e.req, "write data", {24'd0, mem_wdata}, {24'd0, e.data});
            end
        end
    end

    // Drives one command and checks busy/done timing for n accesses.
    task automatic issue(logic [2:0] op, logic [15:0] d, int n, string req, bit poke);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        if (poke) begin
            cmd_op = 3'd1; cmd_data = 16'h00EE;
        end else begin
            cmd_valid = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            chk(req, "busy during access (R10)", {31'd0, busy}, 32'd1);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        chk(req, "done after last access (R10)", {31'd0, done}, 32'd1);
        chk(req, "busy cleared (R10)", {31'd0, busy}, 32'd0);
        chk(req, "pointer", {16'd0, sp}, {16'd0, sp_m});
        @(negedge clk);
        chk(req, "done one cycle (R10)", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] fb [9];
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd7; cmd_data = '0;
        ctx_pc = '0; ctx_y = '0; ctx_x = '0; ctx_a = '0; ctx_b = '0; ctx_ccr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sp in reset", {16'd0, sp}, 32'd0);
        chk("R1", "strobes in reset", {30'd0, mem_we, mem_re}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "sp after reset", {16'd0, sp}, 32'd0);
        chk("R1", "busy/done after reset", {30'd0, busy, done}, 32'd0);

        // R2 load
        sp_m = 16'h0150;
        issue(3'd0, 16'h0150, 0, "R2", 1'b0);

        // R3 pushes
        exp_wr(16'h0150, 8'hA5, "R3"); sp_m = 16'h014F;
        issue(3'd1, 16'h55A5, 1, "R3", 1'b0);
        exp_wr(16'h014F, 8'h3C, "R3"); sp_m = 16'h014E;
        issue(3'd1, 16'h003C, 1, "R3", 1'b0);

        // R4 pulls
        exp_rd(16'h014F, "R4"); sp_m = 16'h014F;
        issue(3'd2, 16'h0000, 1, "R4", 1'b0);
        chk("R4", "pulled byte", {24'd0, pull_data}, 32'h3C);
        exp_rd(16'h0150, "R4"); sp_m = 16'h0150;
        issue(3'd2, 16'h0000, 1, "R4", 1'b0);
        chk("R4", "pulled byte", {24'd0, pull_data}, 32'hA5);

        // R5 call save, R6 return
        exp_wr(16'h0150, 8'h34, "R5"); exp_wr(16'h014F, 8'h12, "R5"); sp_m = 16'h014E;
        issue(3'd3, 16'h1234, 2, "R5", 1'b0);
        exp_rd(16'h014F, "R6"); exp_rd(16'h0150, "R6"); sp_m = 16'h0150;
        issue(3'd4, 16'h0000, 2, "R6", 1'b0);
        chk("R6", "return address", {16'd0, out_pc}, 32'h1234);

        // R7 interrupt save, with a push poked in while busy (R11)
        ctx_pc = 16'hBEEF; ctx_y = 16'h1357; ctx_x = 16'h2468;
        ctx_a = 8'h11; ctx_b = 8'h22; ctx_ccr = 8'hC5;
        fb[0] = 8'hEF; fb[1] = 8'hBE; fb[2] = 8'h57; fb[3] = 8'h13;
        fb[4] = 8'h68; fb[5] = 8'h24; fb[6] = 8'h11; fb[7] = 8'h22; fb[8] = 8'hC5;
        for (int i = 0; i < 9; i++) exp_wr(16'h0150 - 16'(i), fb[i], "R7");
        sp_m = 16'h0147;
        issue(3'd5, 16'h0000, 9, "R7", 1'b1);
        chk("R11", "no access from command while busy", exp_q.size(), 32'd0);

        // R8 restore, context inputs changed so outputs must come from memory
        ctx_pc = 16'h0000; ctx_y = 16'hFFFF; ctx_x = 16'hAAAA;
        ctx_a = 8'h00; ctx_b = 8'h00; ctx_ccr = 8'h00;
        for (int i = 8; i >= 0; i--) exp_rd(16'h0150 - 16'(i), "R8");
        sp_m = 16'h0150;
        issue(3'd6, 16'h0000, 9, "R8", 1'b0);
        chk("R8", "restored pc", {16'd0, out_pc}, 32'hBEEF);
        chk("R8", "restored y", {16'd0, out_y}, 32'h1357);
        chk("R8", "restored x", {16'd0, out_x}, 32'h2468);
        chk("R8", "restored a/b/ccr", {8'd0, out_a, out_b, out_ccr}, 32'h1122C5);

        // R9 wrap
        sp_m = 16'h0000;
        issue(3'd0, 16'h0000, 0, "R9", 1'b0);
        exp_wr(16'h0000, 8'h77, "R9"); sp_m = 16'hFFFF;
        issue(3'd1, 16'h0077, 1, "R9", 1'b0);
        exp_rd(16'h0000, "R9"); sp_m = 16'h0000;
        issue(3'd2, 16'h0000, 1, "R9", 1'b0);
        chk("R9", "byte across wrap", {24'd0, pull_data}, 32'h77);
        sp_m = 16'hFFFF;
        issue(3'd0, 16'hFFFF, 0, "R9", 1'b0);
        exp_rd(16'h0000, "R9"); sp_m = 16'h0000;
        issue(3'd2, 16'h0000, 1, "R9", 1'b0);

        // R11 opcode 7 ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd7; cmd_data = 16'h4321;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11", "no done for opcode 7", {30'd0, busy, done}, 32'd0);
        @(negedge clk);
        chk("R11", "sp unchanged by opcode 7", {16'd0, sp}, {16'd0, sp_m});

        chk("R10", "all expected accesses seen", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule